// File: doc/BRIEF.md
# Device Power State Controller

This block is the power-management capability logic of a bus-attached peripheral. It holds the device's current power state (full-on D0, the intermediate states D1 and D2, and D3hot) and checks every software request to change that state. A request must follow the allowed transition order and must name a state that the device advertises. A rejected request leaves the state as it was and raises an error flag. A separate input models the loss of main power (D3cold). When that input is released, the device returns to D0 and a power-on reset indication is issued.

The block also keeps a wake-enable bit and a per-state wake-capability mask. It drives an active-low wake line when wake is enabled, the current state is wake-capable and a wake source fires. Software reaches everything through a two-word register port. Word 0 is a read-only capability word. Word 1 is the control and status word. Return to D0 from D3hot produces a one-cycle soft-reset indication, unless the device is built to preserve its context.

Top module: `pm_state_ctrl`

## Requirements
- R1: After reset the state is D0, wake is disabled, the wake status and error flag are clear, `wakeN` is high and `resetReq` is low.
- R2: Reading word 0 (`regSel`=0) returns the capability word. Bit 9 is D1 supported and bit 10 is D2 supported. Bits 15:11 are wake capability from D0, D1, D2, D3hot and D3cold, in that order. All other bits are zero.
- R3: Word 1 holds the state in bits 1:0 (00=D0, 01=D1, 10=D2, 11=D3hot), the D3cold flag in bit 2, wake enable in bit 8, wake status in bit 15 and the error flag in bit 16. A write to bits 1:0 that moves to a higher, supported state, or back to D0, is accepted in the next cycle.
- R4: A write requesting a numerically lower state other than D0 is rejected, and the state is left unchanged.
- R5: A write requesting an unsupported state is rejected. D0 and D3hot are always supported. D1 and D2 are supported only when their parameters are set.
- R6: The error flag shows the outcome of the most recent control write. It is set when the write is rejected and cleared when it is accepted. A rejected write never produces a reset pulse.
- R7: A control write with bit 8 set enables wake only if the capability bit of the requested state is set. Otherwise the enable stays clear and the error flag is set. A write with bit 8 clear always disables wake without error.
- R8: The wake status sets when wake is enabled, a wake source is high and the capability bit of the current state is set (the D3cold bit while powered off). `wakeN` is low while the status is set. The status stays set until a control write has bit 15 at 1.
- R9: An accepted move from D3hot to D0 gives a one-cycle `resetReq` with `resetKind`=0, unless context preservation is configured. Moves from D1 or D2 to D0 give no pulse.
- R10: While `powerOff` is high the device is in D3cold: the state reads 11, the D3cold flag is set, and control writes have no effect.
- R11: When `powerOff` falls after D3cold was entered, the state becomes D0 and a one-cycle `resetReq` with `resetKind`=1 is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register select: 0 capability word, 1 control word |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for the selected word |
| wakeSrc | input | 1 | Wake source pending |
| powerOff | input | 1 | Main power removed (D3cold) |
| pmState | output | 2 | Current power state |
| wakeN | output | 1 | Active-low wake event |
| resetReq | output | 1 | One-cycle reset indication |
| resetKind | output | 1 | 1 power-on reset, 0 soft reset, valid with resetReq |

## Verification
Two configurations run in parallel under the same stimulus. One supports D1 and has wake from D1, D3hot and D3cold. The other supports D2 only, has wake from D0 and D2, and preserves context. Every combination of starting state and requested state is swept, so legal raises, returns to D0, downward requests and requests for unsupported states are each told apart, including which returns to D0 produce a soft reset. A second sweep asks for wake enable in each state, fires a wake source and clears the status. This separates enables granted by the mask from enables refused by it, and a status that holds from one that clears on its own. A power-off sequence shows that writes are ignored in D3cold, that wake in D3cold depends on its own capability bit, and that release gives a power-on reset.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int REG_W        = 32;
  localparam int WAKE_W       = 5;
  localparam int COLD_IDX     = 4;
  localparam int CAP_D1_BIT   = 9;
  localparam int CAP_D2_BIT   = 10;
  localparam int CAP_WAKE_LSB = 11;
  localparam int CTL_COLD_BIT = 2;
  localparam int CTL_WEN_BIT  = 8;
  localparam int CTL_WST_BIT  = 15;
  localparam int CTL_ERR_BIT  = 16;

  typedef enum logic [1:0] {
    PM_D0  = 2'd0,
    PM_D1  = 2'd1,
    PM_D2  = 2'd2,
    PM_D3H = 2'd3
  } pmState_e;

  typedef struct packed {
    logic     loadState;
    pmState_e newState;
    logic     loadWake;
    logic     wakeVal;
    logic     setErr;
    logic     clrErr;
    logic     setStatus;
    logic     clrStatus;
    logic     pulseRst;
    logic     rstPor;
    logic     enterCold;
    logic     exitCold;
  } pmStrobe_t;
endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter bit               SUPPORT_D1   = 1'b1,
  parameter bit               SUPPORT_D2   = 1'b0,
  parameter logic [WAKE_W-1:0] WAKE_CAP    = 5'b11010,
  parameter bit               KEEP_CONTEXT = 1'b0
) (
  input  logic       ctlWr,
  input  logic [1:0] reqState,
  input  logic       reqWake,
  input  logic       reqClr,
  input  logic [1:0] curState,
  input  logic       coldQ,
  input  logic       wakeEnQ,
  input  logic       powerOff,
  input  logic       wakeSrc,
  output pmStrobe_t  strb
);
  // one support bit per encoded state; D0 and D3hot always present
  localparam logic [3:0] SUP_MASK = {1'b1, SUPPORT_D2, SUPPORT_D1, 1'b1};

  logic       wrOk;
  logic       goLegal;
  logic       wakeOk;
  logic [2:0] wakeIdx;

  always_comb begin
    wrOk    = ctlWr & ~coldQ;
    goLegal = (reqState == curState) || (reqState == 2'd0) ||
              ((reqState > curState) && SUP_MASK[reqState]);
    wakeOk  = ~reqWake | WAKE_CAP[{1'b0, reqState}];
    wakeIdx = coldQ ? 3'(COLD_IDX) : {1'b0, curState};

    strb           = '0;
    strb.newState  = pmState_e'(reqState);
    strb.loadState = wrOk & goLegal & (reqState != curState);
    strb.loadWake  = wrOk & wakeOk;
    strb.wakeVal   = reqWake;
    strb.setErr    = wrOk & ~(goLegal & wakeOk);
    strb.clrErr    = wrOk & goLegal & wakeOk;
    strb.clrStatus = wrOk & reqClr;
    strb.setStatus = wakeSrc & wakeEnQ & WAKE_CAP[wakeIdx];
    strb.enterCold = powerOff & ~coldQ;
    strb.exitCold  = ~powerOff & coldQ;
    strb.rstPor    = strb.exitCold;
    strb.pulseRst  = strb.exitCold |
                     (strb.loadState && reqState == 2'd0 &&
                      curState == 2'd3 && !KEEP_CONTEXT);
  end
endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter bit                SUPPORT_D1 = 1'b1,
  parameter bit                SUPPORT_D2 = 1'b0,
  parameter logic [WAKE_W-1:0] WAKE_CAP   = 5'b11010
) (
  input  logic             clk,
  input  logic             rstN,
  input  pmStrobe_t        strb,
  input  logic             regSel,
  output logic [REG_W-1:0] regRdData,
  output logic [1:0]       stateOut,
  output logic             coldQ,
  output logic             wakeEnQ,
  output logic             statusQ,
  output logic             resetReq,
  output logic             resetKind
);
  pmState_e stateQ;
  logic     errQ;
  logic [REG_W-1:0] capWord;
  logic [REG_W-1:0] ctlWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= PM_D0;
      coldQ     <= 1'b0;
      wakeEnQ   <= 1'b0;
      statusQ   <= 1'b0;
      errQ      <= 1'b0;
      resetReq  <= 1'b0;
      resetKind <= 1'b0;
    end else begin
      resetReq <= strb.pulseRst;
      if (strb.pulseRst) resetKind <= strb.rstPor;
      if (strb.enterCold) begin
        stateQ <= PM_D3H;
        coldQ  <= 1'b1;
      end else if (strb.exitCold) begin
        stateQ <= PM_D0;
        coldQ  <= 1'b0;
      end else if (strb.loadState) begin
        stateQ <= strb.newState;
      end
      if (strb.loadWake) wakeEnQ <= strb.wakeVal;
      if (strb.setErr) errQ <= 1'b1;
      else if (strb.clrErr) errQ <= 1'b0;
      if (strb.setStatus) statusQ <= 1'b1;
      else if (strb.clrStatus) statusQ <= 1'b0;
    end
  end

  always_comb begin
    capWord = '0;
    capWord[CAP_D1_BIT] = SUPPORT_D1;
    capWord[CAP_D2_BIT] = SUPPORT_D2;
    capWord[CAP_WAKE_LSB +: WAKE_W] = WAKE_CAP;
    ctlWord = '0;
    ctlWord[1:0]          = stateQ;
    ctlWord[CTL_COLD_BIT] = coldQ;
    ctlWord[CTL_WEN_BIT]  = wakeEnQ;
    ctlWord[CTL_WST_BIT]  = statusQ;
    ctlWord[CTL_ERR_BIT]  = errQ;
    regRdData = regSel ? ctlWord : capWord;
    stateOut  = stateQ;
  end
endmodule

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl
  import pm_pkg::*;
#(
  parameter bit                SUPPORT_D1   = 1'b1,
  parameter bit                SUPPORT_D2   = 1'b0,
  parameter logic [WAKE_W-1:0] WAKE_CAP     = 5'b11010,
  parameter bit                KEEP_CONTEXT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             wakeSrc,
  input  logic             powerOff,
  output logic [1:0]       pmState,
  output logic             wakeN,
  output logic             resetReq,
  output logic             resetKind
);
  pmStrobe_t strb;
  logic      coldQ;
  logic      wakeEnQ;
  logic      statusQ;

  pm_ctrl #(
    .SUPPORT_D1(SUPPORT_D1), .SUPPORT_D2(SUPPORT_D2),
    .WAKE_CAP(WAKE_CAP), .KEEP_CONTEXT(KEEP_CONTEXT)
  ) u_ctrl (
    .ctlWr   (regWrEn & regSel),
    .reqState(regWrData[1:0]),
    .reqWake (regWrData[CTL_WEN_BIT]),
    .reqClr  (regWrData[CTL_WST_BIT]),
    .curState(pmState),
    .coldQ   (coldQ),
    .wakeEnQ (wakeEnQ),
    .powerOff(powerOff),
    .wakeSrc (wakeSrc),
    .strb    (strb)
  );

  pm_datapath #(
    .SUPPORT_D1(SUPPORT_D1), .SUPPORT_D2(SUPPORT_D2), .WAKE_CAP(WAKE_CAP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regSel   (regSel),
    .regRdData(regRdData),
    .stateOut (pmState),
    .coldQ    (coldQ),
    .wakeEnQ  (wakeEnQ),
    .statusQ  (statusQ),
    .resetReq (resetReq),
    .resetKind(resetKind)
  );

  assign wakeN = ~statusQ;
endmodule

// File: rtl/pm_state_chk.sv
module pm_state_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regSel,
  input logic        regWrEn,
  input logic [31:0] regWrData,
  input logic        powerOff,
  input logic [1:0]  pmState,
  input logic        wakeN,
  input logic        resetReq,
  input logic        resetKind,
  input logic        coldQ
);
  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regSel && !coldQ && !powerOff && regWrData[1:0] != 2'd0 &&
    regWrData[1:0] < pmState |=> $stable(pmState)); // R4

  AST_WAKE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    !wakeN && !(regWrEn && regSel && regWrData[15] && !coldQ) |=> !wakeN); // R8

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq); // R9

  AST_RST_AT_D0: assert property (@(posedge clk) disable iff (!rstN)
    resetReq && !coldQ |-> pmState == 2'd0); // R9

  AST_COLD_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    coldQ && powerOff && regWrEn && regSel |=> pmState == 2'd3 && coldQ); // R10

  AST_COLD_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(powerOff) && coldQ |=> resetReq && resetKind && pmState == 2'd0); // R11
endmodule

bind pm_state_ctrl pm_state_chk u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
  .regWrData(regWrData), .powerOff(powerOff), .pmState(pmState),
  .wakeN(wakeN), .resetReq(resetReq), .resetKind(resetKind), .coldQ(coldQ)
);

// File: tb/sim_pm_state_ctrl.sv
`timescale 1ns/1ps
module sim_pm_state_ctrl;
  localparam logic [4:0] CAP0 = 5'b11010;
  localparam logic [4:0] CAP1 = 5'b00101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b1, regWrEn = 1'b0, wakeSrc = 1'b0, powerOff = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] rd [2];
  logic [1:0]  pmSt [2];
  logic        wkN [2], rq [2], rk [2];

  int nTests = 0, nFail = 0;
  bit done = 0;
  int expSt [2];
  bit expEn [2], expErr [2], expSts [2], expRst [2], expPor [2];
  bit expCold;

  always #2.5 clk = ~clk;

  pm_state_ctrl #(.SUPPORT_D1(1'b1), .SUPPORT_D2(1'b0), .WAKE_CAP(CAP0), .KEEP_CONTEXT(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(rd[0]), .wakeSrc(wakeSrc), .powerOff(powerOff), .pmState(pmSt[0]),
    .wakeN(wkN[0]), .resetReq(rq[0]), .resetKind(rk[0]));

  pm_state_ctrl #(.SUPPORT_D1(1'b0), .SUPPORT_D2(1'b1), .WAKE_CAP(CAP1), .KEEP_CONTEXT(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(rd[1]), .wakeSrc(wakeSrc), .powerOff(powerOff), .pmState(pmSt[1]),
    .wakeN(wkN[1]), .resetReq(rq[1]), .resetKind(rk[1]));

  function automatic bit sup(int c, int s);
    return s == 0 || s == 3 || (s == 1 && c == 0) || (s == 2 && c == 1);
  endfunction
  function automatic bit cap(int c, int i);
    return c == 0 ? CAP0[i] : CAP1[i];
  endfunction
  function automatic bit legal(int c, int cur, int req);
    return req == cur || req == 0 || (req > cur && sup(c, req));
  endfunction

  task automatic chk(int c, string tag, string what, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s cfg%0d %s: actual %0d expected %0d", tag, c, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    regSel = 1'b1;
    #1;
    for (int c = 0; c < 2; c++) begin
      chk(c, tag, "state", pmSt[c], expSt[c]);
      chk(c, tag, "state field", rd[c][1:0], expSt[c]);
      chk(c, tag, "cold flag", rd[c][2], expCold);
      chk(c, tag, "wake enable", rd[c][8], expEn[c]);
      chk(c, tag, "wake status", rd[c][15], expSts[c]);
      chk(c, tag, "error flag", rd[c][16], expErr[c]);
      chk(c, tag, "wakeN", wkN[c], !expSts[c]);
      chk(c, tag, "resetReq", rq[c], expRst[c]);
      if (expRst[c]) chk(c, tag, "resetKind", rk[c], expPor[c]);
    end
  endtask

  task automatic clrRst();
    for (int c = 0; c < 2; c++) expRst[c] = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    clrRst();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWrEn = 1'b0; wakeSrc = 1'b0; powerOff = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expCold = 0;
    for (int c = 0; c < 2; c++) begin
      expSt[c] = 0; expEn[c] = 0; expErr[c] = 0; expSts[c] = 0; expRst[c] = 0; expPor[c] = 0;
    end
  endtask

  task automatic doWrite(logic [31:0] d);
    @(negedge clk);
    clrRst();
    if (!expCold) begin
      for (int c = 0; c < 2; c++) begin
        int req = int'(d[1:0]);
        bit lg = legal(c, expSt[c], req);
        bit wk = !d[8] || cap(c, req);
        expRst[c] = lg && req == 0 && expSt[c] == 3 && c == 0;
        expPor[c] = 0;
        if (lg) expSt[c] = req;
        if (wk) expEn[c] = d[8];
        expErr[c] = !(lg && wk);
        if (d[15]) expSts[c] = 0;
      end
    end
    regSel = 1'b1; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulseWake();
    @(negedge clk);
    clrRst();
    wakeSrc = 1'b1;
    for (int c = 0; c < 2; c++)
      if (expEn[c] && cap(c, expCold ? 4 : expSt[c])) expSts[c] = 1;
    @(negedge clk);
    wakeSrc = 1'b0;
  endtask

  task automatic setPower(bit off);
    @(negedge clk);
    clrRst();
    powerOff = off;
    for (int c = 0; c < 2; c++) begin
      if (off && !expCold) expSt[c] = 3;
      if (!off && expCold) begin expSt[c] = 0; expRst[c] = 1; expPor[c] = 1; end
    end
    expCold = off;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL R1 watchdog: actual 0 expected 1 (run completion)");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    doReset();
    checkAll("R1");
    regSel = 1'b0;
    #1;
    for (int c = 0; c < 2; c++) begin
      logic [31:0] capExp = '0;
      capExp[9] = sup(c, 1);
      capExp[10] = sup(c, 2);
      for (int i = 0; i < 5; i++) capExp[11 + i] = cap(c, i);
      chk(c, "R2", "capability word", int'(rd[c]), int'(capExp));
    end

    // R3 R4 R5 R6 R9: every start state against every request
    for (int cur = 0; cur < 4; cur++) begin
      for (int req = 0; req < 4; req++) begin
        doReset();
        doWrite(32'(cur));
        checkAll("R3");
        doWrite(32'(req));
        checkAll("R3,R4,R5,R6,R9");
        idle(1);
        checkAll("R9");
      end
    end

    // R7 R8: wake enable and status in each state
    for (int s = 0; s < 4; s++) begin
      doReset();
      doWrite(32'(s));
      doWrite(32'(s) | 32'h100);
      checkAll("R7");
      pulseWake();
      checkAll("R8");
      idle(3);
      checkAll("R8");
      doWrite(32'(s) | 32'h8100);
      checkAll("R8");
      doWrite(32'(s));
      checkAll("R7");
    end

    // R10 R11: power removal and restore
    doReset();
    doWrite(32'h103);
    checkAll("R7");
    setPower(1'b1);
    checkAll("R10");
    doWrite(32'h0);
    checkAll("R10");
    pulseWake();
    checkAll("R10");
    setPower(1'b0);
    checkAll("R11");
    idle(1);
    checkAll("R11");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule